// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small set of sticky flags that tell firmware why the chip last came out of reset. Four reset sources feed it: power-on, brown-out, the external reset pin and the watchdog. Each source raises a one-cycle or longer event input. On every clock edge where a source is active, the matching flag is set.

Firmware reads the flags over a plain register bus with one address. It acknowledges a cause by writing a zero to that flag's bit. A power-on event is special: it sets its own flag and wipes every other flag. The power-on flag itself is cleared only by a software write.

The flags sit outside the general synchronous reset, so a brown-out, pin or watchdog reset leaves the record intact. The general reset clears only the read-data register.

Top module: `rst_cause_reg`

## Requirements
- R1: The register's bit map is fixed: bit 0 is power-on, bit 1 is external pin, bit 2 is brown-out and bit 3 is watchdog. Bits DATA_W-1 down to 4 always read as zero.
- R2: A cycle with `por_evt` high leaves the flags at 4'b0001 after the next edge. This holds whatever other events or writes occur in that cycle.
- R3: Without `por_evt`, a high `bor_evt`, `ext_evt` or `wdt_evt` sets its own flag at the next edge. The other flags are left as they were.
- R4: A write (`wr_en` high, `addr` equal to REG_ADDR) with a zero in a flag's bit clears that flag at the next edge. A one in that bit leaves the flag unchanged, so software can never set a flag.
- R5: When a source event and a software write of zero to the same flag fall in the same cycle, the event wins and the flag ends set.
- R6: The power-on flag is cleared only by a software write of zero. Brown-out, external and watchdog events do not change it.
- R7: The general reset `rst` does not change any flag. It clears `rdata` to zero at the next edge.
- R8: A read with `rd_en` high loads `rdata` at the next edge. If `addr` equals REG_ADDR, `rdata` takes the flag values from before that edge. For any other address it takes zero. With `rd_en` low, `rdata` holds its value.
- R9: A write to any address other than REG_ADDR has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | General synchronous reset, active high; clears only the read data |
| por_evt | input | 1 | Power-on reset event |
| bor_evt | input | 1 | Brown-out reset event |
| ext_evt | input | 1 | External pin reset event |
| wdt_evt | input | 1 | Watchdog reset event |
| addr | input | ADDR_W | Register bus address |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data; a zero in a flag bit clears that flag |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Registered read data |

## Verification
The assertions assume the flags have become defined before `rst` is released. This means `por_evt` must be high for at least one edge while `rst` is held, because the flag storage has no reset of its own. The bench starts with `rst` and `por_evt` high together for two cycles.

After that, the assertions accept any mix of inputs, since every combination of events and bus strobes has a defined outcome. The random stimulus keeps event probabilities low so that flags stay set long enough to be read back and cleared. Rare `por_evt` and `rst` pulses are mixed in, and addresses are drawn across the whole address space.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned BIT_POR = 0;
  localparam int unsigned BIT_EXT = 1;
  localparam int unsigned BIT_BOR = 2;
  localparam int unsigned BIT_WDT = 3;

  typedef struct packed {
    logic wdt;
    logic bor;
    logic ext;
    logic por;
  } src_vec_t;
endpackage

// File: rtl/rcr_flag_cell.sv
module rcr_flag_cell #(
  parameter bit IS_POR_FLAG = 1'b0
) (
  input  logic clk,
  input  logic por,
  input  logic evt,
  input  logic sw_clr,
  output logic flag
);
  logic flag_q;

  generate
    if (IS_POR_FLAG) begin : g_por
      always_ff @(posedge clk) begin
        if (por)         flag_q <= 1'b1;
        else if (sw_clr) flag_q <= 1'b0;
      end
    end else begin : g_src
      always_ff @(posedge clk) begin
        if (por)         flag_q <= 1'b0;
        else if (evt)    flag_q <= 1'b1;
        else if (sw_clr) flag_q <= 1'b0;
      end
    end
  endgenerate

  assign flag = flag_q;
endmodule

// File: rtl/rcr_bus_port.sv
module rcr_bus_port #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NFLAG    = 4,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [NFLAG-1:0]  flags,
  output logic [NFLAG-1:0]  clr_req,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);
  localparam int unsigned PAD_W = DATA_W - NFLAG;

  logic hit;
  logic [DATA_W-1:0] rdata_q;

  assign hit     = (addr == HIT_ADDR);
  assign clr_req = (wr_en && hit) ? ~wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= hit ? {{PAD_W{1'b0}}, flags} : '0;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_evt,
  input  logic              bor_evt,
  input  logic              ext_evt,
  input  logic              wdt_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata
);
  src_vec_t src;
  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] clr_req;
  logic [NUM_SRC-1:0] flag_vec;

  assign src.por = por_evt;
  assign src.ext = ext_evt;
  assign src.bor = bor_evt;
  assign src.wdt = wdt_evt;
  assign evt_vec = src;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    rcr_flag_cell #(.IS_POR_FLAG(i == BIT_POR)) u_cell (
      .clk    (clk),
      .por    (por_evt),
      .evt    (evt_vec[i]),
      .sw_clr (clr_req[i]),
      .flag   (flag_vec[i])
    );
  end

  rcr_bus_port #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NFLAG    (NUM_SRC),
    .REG_ADDR (REG_ADDR)
  ) u_bus (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rd_en   (rd_en),
    .flags   (flag_vec),
    .clr_req (clr_req),
    .rdata   (rdata)
  );
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_ADDR = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              por_evt,
  input logic              bor_evt,
  input logic              ext_evt,
  input logic              wdt_evt,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic [3:0]        flag_vec
);
  logic wr_hit;
  logic any_evt;
  assign wr_hit  = wr_en && (addr == ADDR_W'(REG_ADDR));
  assign any_evt = por_evt | bor_evt | ext_evt | wdt_evt;

  assert_pad_zero_R1: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:4] == '0);

  assert_por_wipes_R2: assert property (@(posedge clk) disable iff (rst)
    por_evt |=> flag_vec == 4'b0001);

  assert_bor_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (bor_evt && !por_evt) |=> flag_vec[2]);

  assert_evt_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wdt_evt && !por_evt && wr_hit && !wdata[3]) |=> flag_vec[3]);

  assert_sw_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wdata[1] && !ext_evt && !por_evt) |=> !flag_vec[1]);

  assert_por_flag_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (!por_evt && !(wr_hit && !wdata[0])) |=> flag_vec[0] == $past(flag_vec[0]));

  assert_quiet_stable_R7: assert property (@(posedge clk)
    ($past(!rst) && !any_evt && !wr_hit) |=> $stable(flag_vec));

  assert_rst_rdata_R7: assert property (@(posedge clk)
    rst |=> rdata == '0);

  assert_read_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(REG_ADDR)) |=> rdata[3:0] == $past(flag_vec));

  assert_no_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_miss_write_R9: assert property (@(posedge clk) disable iff (rst)
    (!any_evt && wr_en && addr != ADDR_W'(REG_ADDR)) |=> $stable(flag_vec));
endmodule

bind rst_cause_reg rst_cause_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .por_evt(por_evt), .bor_evt(bor_evt),
  .ext_evt(ext_evt), .wdt_evt(wdt_evt), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .flag_vec(flag_vec)
);

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned REG_ADDR = 0;

  logic clk = 1'b0;
  logic rst, por_evt, bor_evt, ext_evt, wdt_evt, wr_en, rd_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_flags;
  logic [DATA_W-1:0] m_rdata;

  always #4 clk = ~clk;

  rst_cause_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_rst_cause_reg (
    .clk(clk), .rst(rst), .por_evt(por_evt), .bor_evt(bor_evt),
    .ext_evt(ext_evt), .wdt_evt(wdt_evt), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata)
  );

  function automatic logic [3:0] next_flags(
    logic [3:0] cur, logic p, logic b, logic e, logic w,
    logic hit_wr, logic [3:0] wd);
    logic [3:0] n;
    logic [3:0] ev;
    if (p) return 4'b0001;
    ev = {w, b, e, 1'b0};
    n  = cur;
    if (hit_wr) n = n & wd;
    return n | ev;
  endfunction

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic r, logic p, logic b, logic e, logic w,
                      logic we, logic re, logic [ADDR_W-1:0] a,
                      logic [DATA_W-1:0] wd, string tag, bit do_chk);
    logic hit;
    rst = r; por_evt = p; bor_evt = b; ext_evt = e; wdt_evt = w;
    wr_en = we; rd_en = re; addr = a; wdata = wd;
    hit = (a == ADDR_W'(REG_ADDR));
    @(posedge clk);
    if (r)       m_rdata = '0;
    else if (re) m_rdata = hit ? {4'b0, m_flags} : '0;
    m_flags = next_flags(m_flags, p, b, e, w, we && hit, wd[3:0]);
    @(negedge clk);
    if (do_chk) check(tag, rdata, m_rdata);
  endtask

  task automatic rd(string tag);
    step(0, 0, 0, 0, 0, 0, 1, ADDR_W'(REG_ADDR), '0, tag, 1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_flags = 4'b0000; m_rdata = '0;
    @(negedge clk);
    step(1, 1, 0, 0, 0, 0, 0, 0, '0, "R7", 0);
    step(1, 1, 0, 0, 0, 0, 0, 0, '0, "R7", 1);
    rd("R1 reset state POR only");
    // R3: each source sets its own flag
    step(0, 0, 1, 0, 0, 0, 0, 0, '0, "R3", 0); rd("R3 brown-out bit 2");
    step(0, 0, 0, 1, 0, 0, 0, 0, '0, "R3", 0); rd("R3 external bit 1");
    step(0, 0, 0, 0, 1, 0, 0, 0, '0, "R3", 0); rd("R3 watchdog bit 3");
    // R6: POR flag kept through other events (still 1 above); clear by write
    step(0, 0, 0, 0, 0, 1, 0, ADDR_W'(REG_ADDR), 8'hFE, "R6", 0); rd("R6 sw clears POR");
    // R4: writing ones changes nothing
    step(0, 0, 0, 0, 0, 1, 0, ADDR_W'(REG_ADDR), 8'hFF, "R4", 0); rd("R4 write ones");
    step(0, 0, 0, 0, 0, 1, 0, ADDR_W'(REG_ADDR), 8'hFB, "R4", 0); rd("R4 clear bit 2");
    // R9: write to other address
    step(0, 0, 0, 0, 0, 1, 0, 4'h5, 8'h00, "R9", 0); rd("R9 miss write ignored");
    // R5: event and write-zero together
    step(0, 0, 1, 0, 0, 1, 0, ADDR_W'(REG_ADDR), 8'h00, "R5", 0); rd("R5 event beats clear");
    // R7: general reset leaves flags
    step(1, 0, 0, 0, 0, 0, 1, ADDR_W'(REG_ADDR), '0, "R7 rdata cleared", 1);
    rd("R7 flags survive rst");
    // R2: POR with other events and a write
    step(0, 1, 1, 1, 1, 1, 0, ADDR_W'(REG_ADDR), 8'h00, "R2", 0); rd("R2 POR wipes others");
    // R8: read miss gives zero, hold when idle
    step(0, 0, 0, 0, 0, 0, 1, 4'h3, '0, "R8 read miss zero", 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, '0, "R8 hold", 1);
    // random phase
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] ra;
      ra = ($urandom_range(0, 1) == 0) ? ADDR_W'(REG_ADDR) : ADDR_W'($urandom);
      step(($urandom_range(0, 99) < 2), ($urandom_range(0, 99) < 2),
           ($urandom_range(0, 99) < 6), ($urandom_range(0, 99) < 6),
           ($urandom_range(0, 99) < 6), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 1) == 1), ra, DATA_W'($urandom),
           "R8 random", 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule